// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is a DMA engine that walks a ring of transmit buffer descriptors held in memory. A start strobe launches a walk at the current-pointer address. The block reads each 8-byte descriptor and gathers the bytes of its data buffer into an internal frame store. The descriptor marked last closes the frame. The frame is then padded if requested and streamed out one byte per handshake. After each descriptor has been handled, its first word is written back with the hardware status bits cleared.

The walk ends at the first descriptor whose ready bit is clear. The address of that descriptor is reported so that software can store it as the new current pointer, and a halt flag is raised. Memory is reached through a single request/acknowledge port of 32-bit words. Byte `k` of a word (address offset `k`) sits in bits `[8k+7:8k]`.

Descriptor layout, where offsets are bytes from the descriptor address:

| Offset | Size | Field |
|--------|------|-------|
| 0 | 16 bits | flags |
| 2 | 16 bits | length |
| 4 | 32 bits | buffer pointer |

Flag bits:

| Bit | Meaning |
|-----|---------|
| 15 | ready |
| 14 | pad request |
| 13 | wrap |
| 12 | interrupt |
| 11 | last |
| 10, 6 | kept on write-back |
| 9, 8, 7, 5:2, 1, 0 | status fields, cleared on write-back |

Top module: `txbd_walker`

## Requirements
- R1: With `le_i`=1, each descriptor field is stored least significant byte first. With `le_i`=0, each field is stored most significant byte first. Both the decode and the write-back follow `le_i`.
- R2: The low three bits of `ring_base_i` and of `cur_ptr_i` are ignored, so both are treated as 8-byte aligned.
- R3: The walk stops at the first descriptor whose ready bit (15) is 0. `ptr_o` then carries that descriptor's address during a one-cycle `ptr_valid_o` pulse. `halt_o` is set and stays set until the next accepted start.
- R4: After a descriptor is handled, the next address is the ring base if that descriptor's wrap bit (13) was set as read. Otherwise it is the current address plus 8.
- R5: A frame is the concatenation, in ring order, of the buffer bytes of its descriptors. The buffers may start at any byte address. The descriptor with last bit (11) set closes the frame, and `out_last_o` marks only the final byte of the frame.
- R6: A descriptor with length 0 adds no data, raises no event and does not close the frame, even if its last bit is set. Its first word is written back unchanged, so its ready bit stays set.
- R7: When the pad bit (14) of the first nonzero-length descriptor of a frame is set, or `pad_en_i` is 1, a frame shorter than 60 bytes is sent as 60 bytes, with zeros after the data. Pad bits on later descriptors of the frame have no effect.
- R8: A descriptor with interrupt bit (12) set pulses `evt_frame_o` for one cycle when it closes a frame, and pulses `evt_buf_o` otherwise. The two pulses never occur together.
- R9: Write-back rewrites only the flags/length word. The new flags are the old flags ANDed with 16'h7C40, the length is unchanged, and the pointer word is not written.
- R10: A start with `tx_en_i`=0 is ignored. If `tx_en_i` is 0 when a frame's last descriptor is reached, the frame is dropped without output, but write-back and events still take place.
- R11: While `out_valid_o` is 1 and `out_ready_i` is 0, the output holds its valid, data and last values.
- R12: A start strobe during a walk is ignored.
- R13: A memory request holds its address and direction until it is acknowledged, and only one request is outstanding at a time.
- R14: Frame bytes beyond `FB_DEPTH` are dropped, so the sent frame is the first `FB_DEPTH` bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Walk start strobe |
| tx_en_i | input | 1 | Transmit enable |
| le_i | input | 1 | Descriptor fields least significant byte first |
| pad_en_i | input | 1 | Global pad-to-minimum enable |
| ring_base_i | input | AW | Ring base address |
| cur_ptr_i | input | AW | Address of the first descriptor to walk |
| busy_o | output | 1 | A walk is in progress |
| halt_o | output | 1 | The last walk stopped at a descriptor that was not ready |
| ptr_o | output | AW | Address of the descriptor that stopped the walk |
| ptr_valid_o | output | 1 | `ptr_o` update pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | AW | Memory word address (byte address, 4-aligned) |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |
| out_data_o | output | 8 | Frame byte |
| out_valid_o | output | 1 | Frame byte valid |
| out_last_o | output | 1 | Final byte of the frame |
| out_ready_i | input | 1 | Sink accepts the byte |
| evt_frame_o | output | 1 | Frame-sent event pulse |
| evt_buf_o | output | 1 | Buffer-consumed event pulse |

## Verification
The assertions assume that the memory raises `mem_ack_i` only while a request is pending, for a single cycle, with read data valid in that same cycle. They also assume that the sink may drop `out_ready_i` at any cycle. The bench memory model keeps to this rule: it acknowledges each request after a delay of zero to two cycles. The sink ready follows a pseudo-random pattern, so stalls land mid-frame, including on padding bytes and on the final byte. Descriptor rings are always closed by a descriptor that is not ready, so that every walk ends.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int unsigned BIT_READY = 15;
  localparam int unsigned BIT_PAD   = 14;
  localparam int unsigned BIT_WRAP  = 13;
  localparam int unsigned BIT_IRQ   = 12;
  localparam int unsigned BIT_LAST  = 11;
  // bits preserved on write-back; all others are hardware status
  localparam logic [15:0] WB_KEEP   = 16'h7C40;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_DEC, S_FETCH, S_COPY, S_FIN, S_SEND, S_WB
  } walk_state_e;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/txbd_codec.sv
module txbd_codec
  import txbd_pkg::*;
(
  input  logic        le_i,
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  output logic [15:0] flags_o,
  output logic [15:0] len_o,
  output logic [31:0] ptr_o,
  input  logic [15:0] wb_flags_i,
  input  logic [15:0] wb_len_i,
  output logic [31:0] wb_word_o
);
  // memory lane k holds byte offset k
  always_comb begin
    if (le_i) begin
      flags_o   = w0_i[15:0];
      len_o     = w0_i[31:16];
      ptr_o     = w1_i;
      wb_word_o = {wb_len_i, wb_flags_i};
    end else begin
      flags_o   = swap16(w0_i[15:0]);
      len_o     = swap16(w0_i[31:16]);
      ptr_o     = {w1_i[7:0], w1_i[15:8], w1_i[23:16], w1_i[31:24]};
      wb_word_o = {swap16(wb_len_i), swap16(wb_flags_i)};
    end
  end
endmodule

// File: rtl/txbd_frame_buf.sv
module txbd_frame_buf #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW_L = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            wr_en_i,
  input  logic [AW_L-1:0] wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [AW_L-1:0] rd_addr_i,
  output logic [7:0]      rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/txbd_walker.sv
module txbd_walker
  import txbd_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned FB_DEPTH  = 128,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tx_en_i,
  input  logic          le_i,
  input  logic          pad_en_i,
  input  logic [AW-1:0] ring_base_i,
  input  logic [AW-1:0] cur_ptr_i,
  output logic          busy_o,
  output logic          halt_o,
  output logic [AW-1:0] ptr_o,
  output logic          ptr_valid_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [7:0]    out_data_o,
  output logic          out_valid_o,
  output logic          out_last_o,
  input  logic          out_ready_i,
  output logic          evt_frame_o,
  output logic          evt_buf_o
);
  localparam int unsigned CAP = (FB_DEPTH > MIN_FRAME) ? FB_DEPTH : MIN_FRAME;
  localparam int unsigned LW  = $clog2(CAP + 1);
  localparam int unsigned FAW = (FB_DEPTH > 1) ? $clog2(FB_DEPTH) : 1;

  walk_state_e   state_q;
  logic [AW-1:0] bd_addr_q, base_q, dptr_q, ptr_q;
  logic [31:0]   w0_q, word_q;
  logic [15:0]   flags_q, len_q, rem_q;
  logic [LW-1:0] acc_q, send_len_q, idx_q;
  logic          pad_first_q, halt_q, ptr_vld_q, evt_f_q, evt_b_q;

  logic [15:0]   dec_flags, dec_len, wb_flags;
  logic [31:0]   dec_ptr, wb_word;
  logic [7:0]    byte_sel, fb_rd;
  logic          fb_wr, acc_full, send_last;

  assign wb_flags = (len_q == '0) ? flags_q : (flags_q & WB_KEEP);

  txbd_codec u_codec (
    .le_i       (le_i),
    .w0_i       (w0_q),
    .w1_i       (mem_rdata_i),
    .flags_o    (dec_flags),
    .len_o      (dec_len),
    .ptr_o      (dec_ptr),
    .wb_flags_i (wb_flags),
    .wb_len_i   (len_q),
    .wb_word_o  (wb_word)
  );

  assign acc_full = (acc_q >= LW'(FB_DEPTH));
  assign fb_wr    = (state_q == S_COPY) && !acc_full;
  assign byte_sel = word_q[{dptr_q[1:0], 3'b000} +: 8];

  txbd_frame_buf #(.DEPTH(FB_DEPTH)) u_fbuf (
    .clk_i     (clk_i),
    .wr_en_i   (fb_wr),
    .wr_addr_i (acc_q[FAW-1:0]),
    .wr_data_i (byte_sel),
    .rd_addr_i (idx_q[FAW-1:0]),
    .rd_data_o (fb_rd)
  );

  // memory port
  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = bd_addr_q;
    unique case (state_q)
      S_RD0:   mem_req_o = 1'b1;
      S_RD1:   begin mem_req_o = 1'b1; mem_addr_o = bd_addr_q + AW'(4); end
      S_FETCH: begin mem_req_o = 1'b1; mem_addr_o = {dptr_q[AW-1:2], 2'b00}; end
      S_WB:    begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      default: ;
    endcase
  end
  assign mem_wdata_o = wb_word;

  assign send_last   = (idx_q == send_len_q - LW'(1));
  assign out_valid_o = (state_q == S_SEND);
  assign out_data_o  = (out_valid_o && idx_q < acc_q) ? fb_rd : 8'h00;
  assign out_last_o  = out_valid_o && send_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      bd_addr_q   <= '0;
      base_q      <= '0;
      dptr_q      <= '0;
      ptr_q       <= '0;
      w0_q        <= '0;
      word_q      <= '0;
      flags_q     <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      acc_q       <= '0;
      send_len_q  <= '0;
      idx_q       <= '0;
      pad_first_q <= 1'b0;
      halt_q      <= 1'b0;
      ptr_vld_q   <= 1'b0;
      evt_f_q     <= 1'b0;
      evt_b_q     <= 1'b0;
    end else begin
      ptr_vld_q <= 1'b0;
      evt_f_q   <= 1'b0;
      evt_b_q   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i && tx_en_i) begin
          bd_addr_q <= {cur_ptr_i[AW-1:3], 3'b000};
          base_q    <= {ring_base_i[AW-1:3], 3'b000};
          halt_q    <= 1'b0;
          state_q   <= S_RD0;
        end
        S_RD0: if (mem_ack_i) begin
          w0_q    <= mem_rdata_i;
          state_q <= S_RD1;
        end
        S_RD1: if (mem_ack_i) begin
          flags_q <= dec_flags;
          len_q   <= dec_len;
          dptr_q  <= dec_ptr[AW-1:0];
          state_q <= S_DEC;
        end
        S_DEC: begin
          if (!flags_q[BIT_READY]) begin
            ptr_q     <= bd_addr_q;
            ptr_vld_q <= 1'b1;
            halt_q    <= 1'b1;
            state_q   <= S_IDLE;
          end else if (len_q == '0) begin
            state_q <= S_WB;
          end else begin
            if (acc_q == '0) pad_first_q <= flags_q[BIT_PAD];
            rem_q   <= len_q;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: if (mem_ack_i) begin
          word_q  <= mem_rdata_i;
          state_q <= S_COPY;
        end
        S_COPY: begin
          if (!acc_full) acc_q <= acc_q + LW'(1);
          dptr_q <= dptr_q + AW'(1);
          rem_q  <= rem_q - 16'd1;
          if (rem_q == 16'd1)          state_q <= flags_q[BIT_LAST] ? S_FIN : S_WB;
          else if (dptr_q[1:0] == 2'b11) state_q <= S_FETCH;
        end
        S_FIN: begin
          if (tx_en_i) begin
            if ((pad_first_q || pad_en_i) && acc_q < LW'(MIN_FRAME))
              send_len_q <= LW'(MIN_FRAME);
            else
              send_len_q <= acc_q;
            idx_q   <= '0;
            state_q <= S_SEND;
          end else begin
            state_q <= S_WB;
          end
        end
        S_SEND: if (out_ready_i) begin
          idx_q <= idx_q + LW'(1);
          if (send_last) state_q <= S_WB;
        end
        S_WB: if (mem_ack_i) begin
          if (len_q != '0) begin
            if (flags_q[BIT_LAST]) begin
              evt_f_q <= flags_q[BIT_IRQ];
              acc_q   <= '0;
            end else begin
              evt_b_q <= flags_q[BIT_IRQ];
            end
          end
          bd_addr_q <= flags_q[BIT_WRAP] ? base_q : bd_addr_q + AW'(8);
          state_q   <= S_RD0;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign halt_o      = halt_q;
  assign ptr_o       = ptr_q;
  assign ptr_valid_o = ptr_vld_q;
  assign evt_frame_o = evt_f_q;
  assign evt_buf_o   = evt_b_q;

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  p_out_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  p_ptr_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o |-> ptr_o[2:0] == 3'b000);

  p_evt_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evt_frame_o && evt_buf_o));

  p_halt_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_valid_o |-> halt_o && !busy_o);

  p_start_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !mem_req_o && !out_valid_o |=> busy_o);

  p_pad_floor_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o && pad_en_i |-> idx_q >= LW'(MIN_FRAME - 1));
endmodule

// File: tb/txbd_walker_tb.sv
`timescale 1ns/1ps
module txbd_walker_tb;
  localparam int AW = 16;
  localparam int FBD = 96;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, tx_en = 1'b1, le = 1'b0, pad_en = 1'b0;
  logic [AW-1:0] ring_base = '0, cur_ptr = '0;
  logic busy, halt, ptr_vld, mreq, mwe, mack = 1'b0, ovalid, olast, oready = 1'b1;
  logic evt_f, evt_b;
  logic [AW-1:0] ptr, maddr;
  logic [31:0] mwdata, mrdata = '0;
  logic [7:0] odata;

  always #10 clk = ~clk;

  txbd_walker #(.AW(AW), .FB_DEPTH(FBD), .MIN_FRAME(60)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_en_i(tx_en), .le_i(le),
    .pad_en_i(pad_en), .ring_base_i(ring_base), .cur_ptr_i(cur_ptr),
    .busy_o(busy), .halt_o(halt), .ptr_o(ptr), .ptr_valid_o(ptr_vld),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_ack_i(mack), .mem_rdata_i(mrdata), .out_data_o(odata),
    .out_valid_o(ovalid), .out_last_o(olast), .out_ready_i(oready),
    .evt_frame_o(evt_f), .evt_buf_o(evt_b));

  // host image plus write-back overlay tagged by walk generation
  logic [7:0] mem [0:4095];
  logic [7:0] wbm [0:4095];
  int         wbg [0:4095];
  int gen = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic logic [7:0] rb(input int a);
    return (wbg[a & 12'hFFF] == gen) ? wbm[a & 12'hFFF] : mem[a & 12'hFFF];
  endfunction

  // memory model: ack after 0..2 wait cycles
  int dly = 0, dpat = 0;
  always @(posedge clk) begin
    if (mreq && !mack) begin
      if (dly == 0) begin
        mack <= 1'b1;
        for (int k = 0; k < 4; k++) begin
          if (mwe) begin
            wbm[(int'(maddr) + k) & 12'hFFF] <= mwdata[8*k +: 8];
            wbg[(int'(maddr) + k) & 12'hFFF] <= gen;
          end else begin
            mrdata[8*k +: 8] <= rb(int'(maddr) + k);
          end
        end
        dpat = (dpat + 1) % 5;
        dly  <= (dpat == 1) ? 2 : (dpat == 3) ? 1 : 0;
      end else begin
        dly <= dly - 1;
      end
    end else begin
      mack <= 1'b0;
    end
  end

  // sink and monitors
  logic [7:0] cap [0:255];
  int cap_n, frames, flen [0:3], n_ef, n_eb, n_pv, n_req, n_busy, seen_gen = -1;
  int hs_err = 0, hs_wait = 0, st_err = 0, st_cnt = 0;
  logic [7:0] lfsr = 8'h5A;
  bit bp = 1;
  logic p_req = 0, p_ack = 0, p_we = 0, p_val = 0, p_rdy = 0, p_last = 0;
  logic [AW-1:0] p_addr = '0;
  logic [7:0] p_data = '0;
  int fstart;

  always @(negedge clk) begin
    if (gen != seen_gen) begin
      seen_gen = gen; cap_n = 0; frames = 0; n_ef = 0; n_eb = 0; n_pv = 0;
      n_req = 0; n_busy = 0; fstart = 0;
    end
    if (p_req && !p_ack) begin
      hs_wait++;
      if (!(mreq && maddr == p_addr && mwe == p_we)) hs_err++;
    end
    if (p_val && !p_rdy) begin
      st_cnt++;
      if (!(ovalid && odata == p_data && olast == p_last)) st_err++;
    end
    lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    oready = bp ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (ovalid && oready) begin
      if (cap_n < 256) cap[cap_n] = odata;
      cap_n++;
      if (olast) begin
        if (frames < 4) flen[frames] = cap_n - fstart;
        frames++; fstart = cap_n;
      end
    end
    if (evt_f) n_ef++;
    if (evt_b) n_eb++;
    if (ptr_vld) n_pv++;
    if (mreq) n_req++;
    if (busy) n_busy++;
    p_req = mreq; p_ack = mack; p_addr = maddr; p_we = mwe;
    p_val = ovalid; p_rdy = oready; p_data = odata; p_last = olast;
  end

  // expected frame
  logic [7:0] ex [0:255];
  int ex_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put_bd(input int a, input logic [15:0] f, input logic [15:0] l,
                        input logic [31:0] p);
    if (le) begin
      mem[a] = f[7:0]; mem[a+1] = f[15:8]; mem[a+2] = l[7:0]; mem[a+3] = l[15:8];
      for (int k = 0; k < 4; k++) mem[a+4+k] = p[8*k +: 8];
    end else begin
      mem[a] = f[15:8]; mem[a+1] = f[7:0]; mem[a+2] = l[15:8]; mem[a+3] = l[7:0];
      for (int k = 0; k < 4; k++) mem[a+4+k] = p[8*(3-k) +: 8];
    end
  endtask

  function automatic logic [15:0] rd16(input int a);
    return le ? {rb(a+1), rb(a)} : {rb(a), rb(a+1)};
  endfunction

  function automatic logic [31:0] rd32(input int a);
    return le ? {rd16(a+2), rd16(a)} : {rd16(a), rd16(a+2)};
  endfunction

  task automatic seg(input int p, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      mem[(p+i) & 12'hFFF] = 8'(seed + i*3);
      if (ex_n < 256) ex[ex_n] = 8'(seed + i*3);
      ex_n++;
    end
  endtask

  task automatic walk(input int base, input int cur, input bit mid_start, input bit drop_en);
    int n;
    gen++;
    repeat (2) @(negedge clk);
    ring_base = AW'(base); cur_ptr = AW'(cur);
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (drop_en) tx_en = 1'b0;
    if (mid_start) begin
      repeat (2) @(negedge clk);
      cur_ptr = 16'h0300; start = 1'b1; @(negedge clk); start = 1'b0; cur_ptr = AW'(cur);
    end
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_frame(input string req);
    int bad;
    bad = -1;
    chk(cap_n == ex_n, req, "frame length", cap_n, ex_n);
    for (int i = 0; i < ex_n && i < 256; i++)
      if (bad < 0 && cap[i] !== ex[i]) bad = i;
    chk(bad < 0, req, "first bad byte index", bad, -1);
  endtask

  initial begin
    repeat (4096) ;
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'h00; wbm[i] = 8'h00; wbg[i] = -1; end
  end

  initial begin
    int expl;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !halt && !ovalid && !mreq && !evt_f && !evt_b && !ptr_vld,
        "reset", "idle outputs", {busy, halt, ovalid, mreq}, 0);

    // R1 R2 R3 R5 R8 R9: three-descriptor frame, both byte orders
    for (int e = 0; e < 2; e++) begin
      le = e[0];
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      ex_n = 0;
      put_bd(16'h100, 16'h97FF, 16'd10, 32'h400); seg(16'h400, 10, 8'h11);
      put_bd(16'h108, 16'h8000, 16'd5, 32'h503);  seg(16'h503, 5, 8'h40);
      put_bd(16'h110, 16'h9800, 16'd70, 32'h601); seg(16'h601, 70, 8'h77);
      walk(16'h105, 16'h102, 0, 0);
      cmp_frame(e ? "R1 R5 le" : "R1 R5 be");
      chk(frames == 1 && flen[0] == 85, "R5", "single last marker", flen[0], 85);
      chk(n_eb == 1 && n_ef == 1, "R8", "buf/frame events", n_eb*10 + n_ef, 11);
      chk(ptr == 16'h118 && halt && n_pv == 1, "R3", "stop pointer", ptr, 16'h118);
      chk(rd16(16'h100) == 16'h1440, "R9", "d0 flags written", rd16(16'h100), 16'h1440);
      chk(rd16(16'h110) == 16'h1800, "R9", "d2 flags written", rd16(16'h110), 16'h1800);
      chk(rd16(16'h102) == 16'd10 && rd32(16'h104) == 32'h400, "R9",
          "d0 length and pointer kept", rd16(16'h102), 10);
      chk(wbg[16'h104] != gen, "R9", "pointer word not written", wbg[16'h104], -1);
    end
    le = 1'b0;

    // R4 R2 R12: wrap from misaligned base/pointer, start pulsed mid-walk
    ex_n = 0;
    put_bd(16'h210, 16'hA800, 16'd4, 32'h700); seg(16'h700, 4, 8'h21);
    put_bd(16'h200, 16'h8800, 16'd3, 32'h710); seg(16'h710, 3, 8'h90);
    put_bd(16'h208, 16'h0000, 16'd0, 32'h0);
    walk(16'h203, 16'h215, 1, 0);
    cmp_frame("R4");
    chk(frames == 2 && flen[0] == 4 && flen[1] == 3, "R4", "two frames after wrap",
        frames, 2);
    chk(ptr == 16'h208 && n_pv == 1, "R12", "mid-walk start ignored", ptr, 16'h208);

    // R7 sweep: pad bit on the only descriptor, lengths 1..70
    for (int len = 1; len <= 70; len++) begin
      bit pd;
      pd = len[0];
      ex_n = 0;
      put_bd(0, 16'h8800 | (pd ? 16'h4000 : 16'h0), 16'(len), 32'h800);
      seg(16'h800, len, len);
      put_bd(8, 16'h0000, 16'd0, 32'h0);
      expl = (pd && len < 60) ? 60 : len;
      while (ex_n < expl) begin ex[ex_n] = 8'h00; ex_n++; end
      walk(0, 0, 0, 0);
      begin
        int bad;
        bad = (cap_n == expl) ? -1 : 999;
        for (int i = 0; i < expl; i++) if (bad < 0 && cap[i] !== ex[i]) bad = i;
        chk(bad < 0 && frames == 1, "R7", $sformatf("pad sweep len %0d", len), cap_n, expl);
      end
    end
    // R7: pad bit on a later descriptor has no effect
    ex_n = 0;
    put_bd(0, 16'h8000, 16'd25, 32'h800); seg(16'h800, 25, 3);
    put_bd(8, 16'hC800, 16'd5, 32'h900);  seg(16'h900, 5, 9);
    put_bd(16, 16'h0000, 16'd0, 32'h0);
    walk(0, 0, 0, 0);
    cmp_frame("R7 later pad");
    // R7: global enable
    pad_en = 1'b1;
    for (int len = 59; len <= 61; len++) begin
      ex_n = 0;
      put_bd(0, 16'h8800, 16'(len), 32'h800); seg(16'h800, len, 5);
      put_bd(8, 16'h0000, 16'd0, 32'h0);
      while (ex_n < 60) begin ex[ex_n] = 8'h00; ex_n++; end
      walk(0, 0, 0, 0);
      cmp_frame($sformatf("R7 global len %0d", len));
    end
    pad_en = 1'b0;

    // R6: zero-length descriptors
    ex_n = 0;
    put_bd(0, 16'h9000, 16'd0, 32'h800);
    put_bd(8, 16'h9800, 16'd6, 32'h900); seg(16'h900, 6, 33);
    put_bd(16, 16'h0000, 16'd0, 32'h0);
    walk(0, 0, 0, 0);
    cmp_frame("R6");
    chk(n_eb == 0 && n_ef == 1, "R6", "no event for empty descriptor", n_eb, 0);
    chk(rd16(0) == 16'h9000, "R6", "empty descriptor kept ready", rd16(0), 16'h9000);
    ex_n = 0;
    put_bd(0, 16'h8000, 16'd3, 32'h800); seg(16'h800, 3, 50);
    put_bd(8, 16'h8800, 16'd0, 32'h0);
    put_bd(16, 16'h8800, 16'd2, 32'h900); seg(16'h900, 2, 60);
    put_bd(24, 16'h0000, 16'd0, 32'h0);
    walk(0, 0, 0, 0);
    chk(frames == 1 && flen[0] == 5, "R6", "empty last does not close", flen[0], 5);
    cmp_frame("R6 empty last");

    // R10: start with transmit disabled
    tx_en = 1'b0;
    gen++;
    repeat (2) @(negedge clk);
    put_bd(0, 16'h8800, 16'd4, 32'h800);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_busy == 0 && n_req == 0, "R10", "disabled start ignored", n_req, 0);
    tx_en = 1'b1;

    // R10: transmit dropped during the walk
    put_bd(0, 16'h8000, 16'd40, 32'h800);
    put_bd(8, 16'h9800, 16'd4, 32'h900);
    put_bd(16, 16'h0000, 16'd0, 32'h0);
    walk(0, 0, 0, 1);
    chk(cap_n == 0, "R10", "frame dropped", cap_n, 0);
    chk(n_ef == 1 && rd16(8) == 16'h1800 && ptr == 16'h10, "R10",
        "write-back and event kept", rd16(8), 16'h1800);
    tx_en = 1'b1;

    // R14: frame longer than the store
    ex_n = 0;
    put_bd(0, 16'h8800, 16'd100, 32'h800); seg(16'h800, 100, 7);
    put_bd(8, 16'h0000, 16'd0, 32'h0);
    ex_n = FBD;
    walk(0, 0, 0, 0);
    cmp_frame("R14");

    chk(st_cnt > 0 && st_err == 0, "R11", "stall stability errors", st_err, 0);
    chk(hs_wait > 0 && hs_err == 0, "R13", "request hold errors", hs_err, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule